// File: doc/BRIEF.md
# SPI Frame-Count Command Controller

This block holds the 32-bit command word of an SPI core and turns software writes into control for the neighbouring transmit FIFO, receive FIFO, frame counter and shifter. Three command bits are one-shot actions. Writing one to them produces a single-cycle pulse that resets a FIFO or clears the frame counter, and they always read back as zero. The frame-counter clear pulse is also raised while the core is disabled and when software rewrites the frame-count limit.

Four command bits are sticky modes, and each one ends on its own hardware event. Zero-fill pushes empty frames into the transmit path until the programmed frame count is reached. Receive-discard drops incoming frames until that count is reached or, in slave mode, until slave select goes inactive. Packet-stall makes a master wait until a whole packet is queued, and ends when sending begins. Early-release drops the slave's transmit-busy indication at once, and ends after the first frame leaves. Writing zero never clears a mode. A software set and a hardware clear in the same cycle leave the mode set. The upper 25 bits are plain storage, so read-modify-write sequences keep them.

Top module: `spi_cmd_ctrl`

## Requirements
- R1: After reset, `rd_data` is zero and every output (`rx_fifo_rst`, `tx_fifo_rst`, `cnt_clr`, `fill_zero`, `drop_rx`, `tx_hold`, `tx_busy` with `slave_mode` low) is low.
- R2: A write with bit 2 set pulses `rx_fifo_rst`, with bit 3 set pulses `tx_fifo_rst`, and with bit 4 set pulses `cnt_clr`. Each pulse is high for exactly the one cycle after the write edge. Bits 4:2 of `rd_data` always read zero.
- R3: `cnt_clr` is also high in the cycle after any edge that sees `core_en` low or `limit_wr` high.
- R4: Sticky mode bits sit at positions 0 (zero-fill), 1 (receive-discard), 5 (packet-stall) and 6 (early-release). A write with one in such a position sets that bit, visible in `rd_data` from the next cycle. A zero in that position leaves the bit unchanged.
- R5: Bits 31:7 of `rd_data` return the value of the most recent write to them.
- R6: Zero-fill drives `fill_zero`. It clears on an edge that sees `frame_limit_hit`, or a write with bit 4 set.
- R7: Receive-discard drives `drop_rx`. It clears on an edge that sees `frame_limit_hit`, a write with bit 4 set, or (with `slave_mode` high) `ssel_active` falling from one cycle to the next. A fall of `ssel_active` in master mode leaves it set.
- R8: Packet-stall clears on an edge that sees `tx_start`. `tx_hold` is high exactly when packet-stall is set, `slave_mode` is low and `tx_level < pkt_size`.
- R9: Early-release clears on an edge that sees `tx_frame_done`. `tx_busy` is high exactly when `slave_mode` is high, early-release is clear and `tx_level < pkt_size`.
- R10: When a write sets a sticky bit in the same cycle as that bit's clearing event, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 32 | Command write value |
| rd_data | output | 32 | Current command word |
| core_en | input | 1 | Core enabled; low clears the frame counter |
| limit_wr | input | 1 | Frame-count limit registers written this cycle |
| slave_mode | input | 1 | Core operates as slave |
| ssel_active | input | 1 | Slave select asserted |
| frame_limit_hit | input | 1 | Programmed frame count reached |
| tx_start | input | 1 | Transmission of a packet begins |
| tx_frame_done | input | 1 | A data frame has been transmitted |
| tx_level | input | 4 | Frames held in transmit FIFO |
| pkt_size | input | 4 | Programmed packet size in frames |
| rx_fifo_rst | output | 1 | Receive FIFO reset pulse |
| tx_fifo_rst | output | 1 | Transmit FIFO reset pulse |
| cnt_clr | output | 1 | Frame counter clear |
| fill_zero | output | 1 | Insert zero frames in transmit path |
| drop_rx | output | 1 | Discard received frames |
| tx_hold | output | 1 | Master must not start transmitting |
| tx_busy | output | 1 | Slave transmit-busy indication |

## Verification
The checker's properties assume that the core's event inputs are single-cycle pulses that are sampled on the clock, and that `wr_data` only matters while `wr_en` is high. They are checked against the internally synchronised reset, so the first cycles after release are not judged. The bench drives every input on the falling edge and raises each event for exactly one cycle. Before each slave-select fall it holds `ssel_active` high for a full cycle, so every fall it produces is one the block can see.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int unsigned CMD_W    = 32;
  localparam int unsigned LVL_W    = 4;
  // positions the software driver relies on
  localparam int unsigned B_FILL   = 0;
  localparam int unsigned B_EMPTY  = 1;
  localparam int unsigned B_RXRST  = 2;
  localparam int unsigned B_TXRST  = 3;
  localparam int unsigned B_CNTCLR = 4;
  localparam int unsigned B_STALL  = 5;
  localparam int unsigned B_TXNOW  = 6;
  localparam int unsigned RSVD_LO  = 7;
  localparam int unsigned RSVD_W   = CMD_W - RSVD_LO;
  localparam int unsigned N_STICKY = 4;

  // sticky mode index -> command bit position
  function automatic int unsigned sticky_pos(input int unsigned idx);
    case (idx)
      0:       return B_FILL;
      1:       return B_EMPTY;
      2:       return B_STALL;
      default: return B_TXNOW;
    endcase
  endfunction
endpackage

// File: rtl/spi_cmd_sticky.sv
module spi_cmd_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;

  // set wins over clear
  always_comb begin
    q_d = q_o;
    if (clr_i) q_d = 1'b0;
    if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_d;
  end
endmodule

// File: rtl/spi_cmd_strobes.sv
module spi_cmd_strobes
  import spi_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wr_data,
  input  logic             core_en,
  input  logic             limit_wr,
  output logic             rx_rst_o,
  output logic             tx_rst_o,
  output logic             cnt_clr_o
);
  logic rx_d, tx_d, cnt_d;

  always_comb begin
    rx_d  = wr_en & wr_data[B_RXRST];
    tx_d  = wr_en & wr_data[B_TXRST];
    cnt_d = (wr_en & wr_data[B_CNTCLR]) | ~core_en | limit_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rst_o  <= 1'b0;
      tx_rst_o  <= 1'b0;
      cnt_clr_o <= 1'b0;
    end else begin
      rx_rst_o  <= rx_d;
      tx_rst_o  <= tx_d;
      cnt_clr_o <= cnt_d;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{wr_data[CMD_W-1:B_CNTCLR+1], wr_data[B_RXRST-1:0]};
endmodule

// File: rtl/spi_cmd_gates.sv
module spi_cmd_gates #(
  parameter int unsigned LW = 4
) (
  input  logic          stall_q,
  input  logic          txnow_q,
  input  logic          slave_mode,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] pkt_size,
  output logic          tx_hold,
  output logic          tx_busy
);
  logic short_pkt;

  always_comb begin
    short_pkt = tx_level < pkt_size;
    tx_hold   = stall_q & ~slave_mode & short_pkt;
    tx_busy   = slave_mode & ~txnow_q & short_pkt;
  end
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic             core_en,
  input  logic             limit_wr,
  input  logic             slave_mode,
  input  logic             ssel_active,
  input  logic             frame_limit_hit,
  input  logic             tx_start,
  input  logic             tx_frame_done,
  input  logic [3:0]       tx_level,
  input  logic [3:0]       pkt_size,
  output logic             rx_fifo_rst,
  output logic             tx_fifo_rst,
  output logic             cnt_clr,
  output logic             fill_zero,
  output logic             drop_rx,
  output logic             tx_hold,
  output logic             tx_busy
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  // slave-select fall detect
  logic ssel_q, ssel_fall;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) ssel_q <= 1'b0;
    else         ssel_q <= ssel_active;
  end
  assign ssel_fall = ssel_q & ~ssel_active;

  // one-shot actions
  spi_cmd_strobes u_strb (
    .clk       (clk),
    .rst_n     (rst_sn),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .core_en   (core_en),
    .limit_wr  (limit_wr),
    .rx_rst_o  (rx_fifo_rst),
    .tx_rst_o  (tx_fifo_rst),
    .cnt_clr_o (cnt_clr)
  );

  // sticky modes
  logic                sw_cnt_clr;
  logic [N_STICKY-1:0] mode_clr, mode_q;
  assign sw_cnt_clr = wr_en & wr_data[B_CNTCLR];

  always_comb begin
    mode_clr[0] = frame_limit_hit | sw_cnt_clr;
    mode_clr[1] = frame_limit_hit | sw_cnt_clr | (slave_mode & ssel_fall);
    mode_clr[2] = tx_start;
    mode_clr[3] = tx_frame_done;
  end

  for (genvar i = 0; i < N_STICKY; i++) begin : g_mode
    spi_cmd_sticky u_bit (
      .clk   (clk),
      .rst_n (rst_sn),
      .set_i (wr_en & wr_data[sticky_pos(i)]),
      .clr_i (mode_clr[i]),
      .q_o   (mode_q[i])
    );
  end

  // preserved upper field
  logic [RSVD_W-1:0] rsvd_q, rsvd_d;
  always_comb rsvd_d = wr_en ? wr_data[CMD_W-1:RSVD_LO] : rsvd_q;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) rsvd_q <= '0;
    else         rsvd_q <= rsvd_d;
  end

  always_comb begin
    rd_data                   = '0;
    rd_data[CMD_W-1:RSVD_LO]  = rsvd_q;
    rd_data[B_FILL]           = mode_q[0];
    rd_data[B_EMPTY]          = mode_q[1];
    rd_data[B_STALL]          = mode_q[2];
    rd_data[B_TXNOW]          = mode_q[3];
  end

  assign fill_zero = mode_q[0];
  assign drop_rx   = mode_q[1];

  spi_cmd_gates #(.LW(LVL_W)) u_gate (
    .stall_q    (mode_q[2]),
    .txnow_q    (mode_q[3]),
    .slave_mode (slave_mode),
    .tx_level   (tx_level),
    .pkt_size   (pkt_size),
    .tx_hold    (tx_hold),
    .tx_busy    (tx_busy)
  );
endmodule

// File: rtl/spi_cmd_chk.sv
module spi_cmd_chk (
  input logic        clk,
  input logic        rst_sn,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        frame_limit_hit,
  input logic        tx_start,
  input logic        slave_mode,
  input logic        rx_fifo_rst,
  input logic        fill_zero,
  input logic        tx_busy
);
  // R2
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_en && wr_data[2]) |=> rx_fifo_rst);
  // R2
  action_read_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_data[4:2] == 3'b000);
  // R4
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!(wr_en && (wr_data[0] || wr_data[4])) && !frame_limit_hit) |=> $stable(fill_zero));
  // R8
  stall_end_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (tx_start && !(wr_en && wr_data[5])) |=> !rd_data[5]);
  // R10
  stall_set_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_en && wr_data[5]) |=> rd_data[5]);
  // R9
  busy_mode_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    tx_busy |-> slave_mode);
endmodule

bind spi_cmd_ctrl spi_cmd_chk u_chk (
  .clk             (clk),
  .rst_sn          (rst_sn),
  .wr_en           (wr_en),
  .wr_data         (wr_data),
  .rd_data         (rd_data),
  .frame_limit_hit (frame_limit_hit),
  .tx_start        (tx_start),
  .slave_mode      (slave_mode),
  .rx_fifo_rst     (rx_fifo_rst),
  .fill_zero       (fill_zero),
  .tx_busy         (tx_busy)
);

// File: tb/sim_spi_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_spi_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, wr_en, core_en, limit_wr, slave_mode, ssel_active;
  logic        frame_limit_hit, tx_start, tx_frame_done;
  logic [31:0] wr_data, rd_data;
  logic [3:0]  tx_level, pkt_size;
  logic        rx_fifo_rst, tx_fifo_rst, cnt_clr, fill_zero, drop_rx, tx_hold, tx_busy;

  always #4 clk = ~clk;

  spi_cmd_ctrl u0 (.*);

  int n_chk = 0, n_bad = 0;
  logic m_fill, m_empty, m_stall, m_txnow;
  logic [24:0] m_rsvd;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd();
    return {m_rsvd, m_txnow, m_stall, 3'b000, m_empty, m_fill};
  endfunction

  task automatic chk_state(input string req);
    chk({req, " rd_data"}, rd_data, exp_rd());
    chk({req, " fill_zero"}, {31'd0, fill_zero}, {31'd0, m_fill});
    chk({req, " drop_rx"}, {31'd0, drop_rx}, {31'd0, m_empty});
  endtask

  // drive a write, optionally with one event in the same cycle
  task automatic do_wr(input logic [31:0] d, input int unsigned ev);
    wr_en = 1'b1; wr_data = d;
    frame_limit_hit = (ev == 1); tx_start = (ev == 2); tx_frame_done = (ev == 3);
    @(negedge clk);
    wr_en = 1'b0; frame_limit_hit = 1'b0; tx_start = 1'b0; tx_frame_done = 1'b0;
    if (ev == 1) begin m_fill = 1'b0; m_empty = 1'b0; end
    if (ev == 2) m_stall = 1'b0;
    if (ev == 3) m_txnow = 1'b0;
    if (d[4]) begin m_fill = 1'b0; m_empty = 1'b0; end
    m_fill  = m_fill  | d[0];
    m_empty = m_empty | d[1];
    m_stall = m_stall | d[5];
    m_txnow = m_txnow | d[6];
    m_rsvd  = d[31:7];
    chk("R2 rx_fifo_rst", {31'd0, rx_fifo_rst}, {31'd0, d[2]});
    chk("R2 tx_fifo_rst", {31'd0, tx_fifo_rst}, {31'd0, d[3]});
    chk("R2 cnt_clr",     {31'd0, cnt_clr},     {31'd0, d[4]});
    chk_state(ev != 0 ? "R10" : "R4 R5");
  endtask

  // single event, no write
  task automatic do_ev(input int unsigned k);
    if (k == 1 || k == 4) begin
      slave_mode = (k == 1); ssel_active = 1'b1;
      @(negedge clk);
      ssel_active = 1'b0;
      @(negedge clk);
      slave_mode = 1'b0;
      if (k == 1) m_empty = 1'b0;
      chk_state("R7");
    end else begin
      frame_limit_hit = (k == 0); tx_start = (k == 2); tx_frame_done = (k == 3);
      @(negedge clk);
      frame_limit_hit = 1'b0; tx_start = 1'b0; tx_frame_done = 1'b0;
      if (k == 0) begin m_fill = 1'b0; m_empty = 1'b0; end
      if (k == 2) m_stall = 1'b0;
      if (k == 3) m_txnow = 1'b0;
      chk_state(k == 0 ? "R6" : (k == 2 ? "R8" : "R9"));
    end
    chk("R2 pulse width", {29'd0, rx_fifo_rst, tx_fifo_rst, cnt_clr}, 32'd0);
  endtask

  task automatic sweep_gates();
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 16; p++) begin
        for (int l = 0; l < 16; l++) begin
          slave_mode = s[0]; pkt_size = p[3:0]; tx_level = l[3:0];
          #1;
          chk("R8 tx_hold", {31'd0, tx_hold}, {31'd0, m_stall & (s == 0) & (l < p)});
          chk("R9 tx_busy", {31'd0, tx_busy}, {31'd0, !m_txnow & (s == 1) & (l < p)});
        end
      end
    end
    slave_mode = 1'b0; tx_level = 4'd0; pkt_size = 4'd0;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; core_en = 1'b1; limit_wr = 1'b0;
    slave_mode = 1'b0; ssel_active = 1'b0; frame_limit_hit = 1'b0;
    tx_start = 1'b0; tx_frame_done = 1'b0; tx_level = 4'd0; pkt_size = 4'd0;
    m_fill = 0; m_empty = 0; m_stall = 0; m_txnow = 0; m_rsvd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk_state("R1");
    chk("R1 strobes", {29'd0, rx_fifo_rst, tx_fifo_rst, cnt_clr}, 32'd0);
    chk("R1 tx_hold/tx_busy", {30'd0, tx_hold, tx_busy}, 32'd0);

    // R4 R5 R6 R7 R8 R9: every low-bit pattern, each followed by an event
    for (int v = 0; v < 128; v++) begin
      do_wr({v[24:0] * 25'h9E37, v[6:0]}, 0);
      do_ev(v % 5);
    end

    // R3: disable and limit rewrite clear the counter
    core_en = 1'b0;
    @(negedge clk); core_en = 1'b1;
    chk("R3 cnt_clr core_en", {31'd0, cnt_clr}, 32'd1);
    @(negedge clk);
    chk("R3 cnt_clr released", {31'd0, cnt_clr}, 32'd0);
    limit_wr = 1'b1;
    @(negedge clk); limit_wr = 1'b0;
    chk("R3 cnt_clr limit_wr", {31'd0, cnt_clr}, 32'd1);
    chk_state("R3");

    // R10: set and clear in the same cycle
    do_wr(32'h0000_0003, 1);
    do_wr(32'h0000_0020, 2);
    do_wr(32'h0000_0040, 3);
    do_wr(32'h0000_0013, 0);

    // R8 R9: gate sweeps with both mode combinations
    do_wr(32'h0000_0020, 3);
    sweep_gates();
    do_wr(32'h0000_0040, 2);
    sweep_gates();

    // R4: writing zero clears nothing
    do_wr(32'h0000_0063, 0);
    do_wr(32'hFFFF_FF80, 0);
    do_ev(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule